// File: doc/BRIEF.md
# Four-Phase Byte Execute Core

This block is a byte-wide execution core that runs every instruction word over four clock phases: decode, operand read, compute and write-back. A 16-bit instruction word is taken from a word-addressed program memory port. A byte-wide data memory port with a 12-bit address is read and written through that port. The core holds a working register `W`, a 4-bit bank register and three flags: negative, zero and carry.

Two operations are recognised. The first is a logical AND of `W` with a data-memory byte. Its result goes either to `W` or back to the same memory byte, and the byte is reached either through a fixed split bank or through the bank register. The second is a PC-relative branch taken when carry is set. A taken branch is followed by one instruction cycle in which nothing happens. Every other opcode only advances the PC.

A preload input stalls the core at the start of an instruction and loads `W`, carry and the bank register. A debug view shows the PC, `W` and the flags.

Top module: `quad_phase_core`

## Requirements
- R1: While reset is low, the PC, `W`, the bank register and all three flags read zero, and neither memory enable is high.
- R2: An AND word has bits [15:10] = 000101, destination bit d at [9], bank bit a at [8] and file address f at [7:0]. With d=0, `W` becomes `W & mem[addr]` and memory is left unchanged.
- R3: With d=1, the AND result is written to the same memory byte and `W` keeps its value.
- R4: With a=0, an f below 0x80 addresses 0x000+f and an f of 0x80 or above addresses 0xF00+f, whatever the bank register holds.
- R5: With a=1, the 12-bit data address is the bank register followed by f.
- R6: An AND sets N to bit 7 of its result and Z when the result is 0x00, and it leaves carry unchanged.
- R7: Every instruction cycle lasts exactly four clocks. For an AND, the read enable is high only in the second clock, and the write enable (d=1) is high only in the fourth clock.
- R8: A branch word has bits [15:8] = 11100010 and a signed offset n at [7:0]. With carry set, the next PC is PC+2+2n (modulo the PC width). No flag changes.
- R9: With carry clear, the branch falls through to PC+2 after one instruction cycle, and the next word runs at once.
- R10: After a taken branch, the following instruction cycle has no memory access and does not change the PC. The word at the target runs in the cycle after it.
- R11: Any other opcode, including 0x18xx and 0xE3xx, changes only the PC, which advances by 2.
- R12: While preload is high, the PC and memory are untouched, `W`, carry and the bank register take the preload values, and the core waits at the start of decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_word_addr | output | 15 | Program memory word address (PC without bit 0) |
| pm_rdata | input | 16 | Instruction word, combinational read |
| dm_addr | output | 12 | Data memory byte address |
| dm_rd_en | output | 1 | Data read strobe (operand phase) |
| dm_rdata | input | 8 | Data memory read byte, combinational |
| dm_wr_en | output | 1 | Data write strobe (write-back phase) |
| dm_wdata | output | 8 | Data memory write byte |
| pre_en | input | 1 | Preload and stall |
| pre_w | input | 8 | Preload value for `W` |
| pre_carry | input | 1 | Preload value for carry |
| pre_bsr | input | 4 | Preload value for the bank register |
| dbg_pc | output | 16 | Current byte PC |
| dbg_w | output | 8 | Working register |
| dbg_n | output | 1 | Negative flag |
| dbg_z | output | 1 | Zero flag |
| dbg_c | output | 1 | Carry flag |

## Verification
Several rules are checked on every clock:
- the phase counter steps by one through each instruction cycle;
- a memory write always comes two clocks after a read;
- the PC stays even and is frozen through the idle cycle after a taken branch;
- an AND never touches carry, and a branch never touches any flag.

Other behaviour shows only in the bench's scenarios: the numeric AND results, the two bank mappings, the exact branch targets including wrap-around below zero, the handling of unknown opcodes, and the fact that the target word runs only after the idle cycle.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef logic [1:0] phase_t;

  localparam phase_t PH_DECODE = 2'd0;
  localparam phase_t PH_READ   = 2'd1;
  localparam phase_t PH_PROC   = 2'd2;
  localparam phase_t PH_WRITE  = 2'd3;

  localparam int unsigned IW = 16;
  localparam int unsigned DW = 8;

  localparam logic [5:0] OPC_AND_FILE  = 6'b000101;
  localparam logic [7:0] OPC_BR_CARRY  = 8'b11100010;

  // AND of working register and operand
  function automatic logic [DW-1:0] and_byte(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a & b;
  endfunction

  // flags derived from a result byte: {neg, zero}
  function automatic logic [1:0] nz_of(input logic [DW-1:0] r);
    return {r[DW-1], (r == '0)};
  endfunction

endpackage

// File: rtl/qpc_sequencer.sv
module qpc_sequencer
  import qpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hold,
  input  logic   br_taken,
  output phase_t phase,
  output logic   flush
);

  phase_t phase_q;
  logic   flush_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DECODE;
      flush_q <= 1'b0;
    end else if (hold) begin
      phase_q <= PH_DECODE;
      flush_q <= 1'b0;
    end else begin
      phase_q <= phase_q + 2'd1;
      if (phase_q == PH_WRITE) flush_q <= br_taken;
    end
  end

  assign phase = phase_q;
  assign flush = flush_q;

  // R7: four phases in strict order
  a_r7_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (phase_q == $past(phase_q) + 2'd1));

  // R12: a stall parks the core at decode
  a_r12_hold_decode: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (phase_q == PH_DECODE));

  // R10: the idle cycle lasts one instruction cycle only
  a_r10_flush_once: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_q && phase_q == PH_WRITE && !hold) |=> !flush_q);

endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
#(
  parameter int unsigned BANK_W    = 4,
  parameter logic [7:0]  ACC_SPLIT = 8'h80,
  localparam int unsigned DA_W     = BANK_W + 8
) (
  input  logic [IW-1:0]     ir,
  input  logic              exec,
  input  logic [BANK_W-1:0] bsr,
  output logic              is_and,
  output logic              is_bc,
  output logic              dst_file,
  output logic [DA_W-1:0]   file_addr,
  output logic [7:0]        br_off
);

  // bank mapping: split access bank or bank register
  function automatic logic [DA_W-1:0] map_addr(input logic [7:0] f, input logic use_bank,
                                               input logic [BANK_W-1:0] bank);
    if (use_bank) return {bank, f};
    return {{BANK_W{(f >= ACC_SPLIT)}}, f};
  endfunction

  always_comb begin
    is_and    = exec && (ir[15:10] == OPC_AND_FILE);
    is_bc     = exec && (ir[15:8] == OPC_BR_CARRY);
    dst_file  = ir[9];
    file_addr = map_addr(ir[7:0], ir[8], bsr);
    br_off    = ir[7:0];
  end

endmodule

// File: rtl/qpc_datapath.sv
module qpc_datapath
  import qpc_pkg::*;
#(
  parameter int unsigned BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic              hold,
  input  logic [DW-1:0]     pre_w,
  input  logic              pre_c,
  input  logic [BANK_W-1:0] pre_bsr,
  input  logic [IW-1:0]     pm_rdata,
  input  logic [DW-1:0]     dm_rdata,
  input  logic              is_and,
  input  logic              is_bc,
  input  logic              dst_file,
  output logic [IW-1:0]     ir,
  output logic [BANK_W-1:0] bsr,
  output logic [DW-1:0]     w,
  output logic              n_flag,
  output logic              z_flag,
  output logic              c_flag,
  output logic              rd_en,
  output logic              wr_en,
  output logic [DW-1:0]     wdata,
  output logic              br_taken
);

  logic [IW-1:0]     ir_q;
  logic [DW-1:0]     w_q, opnd_q, res_q;
  logic [BANK_W-1:0] bsr_q;
  logic              n_q, z_q, c_q;

  // named phase events
  logic ev_fetch, ev_read, ev_proc, ev_write;
  assign ev_fetch = !hold && phase == PH_DECODE;
  assign ev_read  = !hold && phase == PH_READ  && is_and;
  assign ev_proc  = !hold && phase == PH_PROC  && is_and;
  assign ev_write = !hold && phase == PH_WRITE && is_and;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q   <= '0;
      w_q    <= '0;
      opnd_q <= '0;
      res_q  <= '0;
      bsr_q  <= '0;
      n_q    <= 1'b0;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
    end else if (hold) begin
      w_q   <= pre_w;
      c_q   <= pre_c;
      bsr_q <= pre_bsr;
    end else begin
      if (ev_fetch) ir_q   <= pm_rdata;
      if (ev_read)  opnd_q <= dm_rdata;
      if (ev_proc)  res_q  <= and_byte(w_q, opnd_q);
      if (ev_write) begin
        if (!dst_file) w_q <= res_q;
        {n_q, z_q} <= nz_of(res_q);
      end
    end
  end

  assign ir       = ir_q;
  assign bsr      = bsr_q;
  assign w        = w_q;
  assign n_flag   = n_q;
  assign z_flag   = z_q;
  assign c_flag   = c_q;
  assign rd_en    = ev_read;
  assign wr_en    = ev_write && dst_file;
  assign wdata    = res_q;
  assign br_taken = (phase == PH_WRITE) && is_bc && c_q;

  // R6: AND leaves carry alone
  a_r6_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> $stable(c_q));

  // R8: branch touches no flag
  a_r8_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WRITE && is_bc && !hold) |=> $stable({n_q, z_q, c_q}));

  // R3: memory destination keeps W
  a_r3_w_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(w_q));

endmodule

// File: rtl/qpc_pc.sv
module qpc_pc
  import qpc_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  phase_t          phase,
  input  logic            hold,
  input  logic            exec,
  input  logic            br_taken,
  input  logic [7:0]      br_off,
  output logic [PC_W-1:0] pc,
  output logic [PC_W-2:0] word_addr
);

  logic [PC_W-1:0] pc_q;

  // PC + 2 + 2n, n signed
  function automatic logic [PC_W-1:0] rel_target(input logic [PC_W-1:0] base, input logic [7:0] off);
    logic [PC_W-1:0] disp;
    disp = {{(PC_W-9){off[7]}}, off, 1'b0};
    return base + PC_W'(2) + disp;
  endfunction

  logic ev_retire;
  assign ev_retire = !hold && exec && phase == PH_WRITE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else if (ev_retire) pc_q <= br_taken ? rel_target(pc_q, br_off) : pc_q + PC_W'(2);
  end

  assign pc        = pc_q;
  assign word_addr = pc_q[PC_W-1:1];

  // R10: idle cycle does not move the PC
  a_r10_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(pc_q));

  // R9: fall-through steps by two
  a_r9_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_retire && !br_taken) |=> (pc_q == $past(pc_q) + PC_W'(2)));

  // R8: byte PC stays even
  a_r8_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[0] == 1'b0);

endmodule

// File: rtl/quad_phase_core.sv
module quad_phase_core
  import qpc_pkg::*;
#(
  parameter int unsigned PC_W      = 16,
  parameter int unsigned BANK_W    = 4,
  parameter logic [7:0]  ACC_SPLIT = 8'h80,
  localparam int unsigned DA_W     = BANK_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-2:0]   pm_word_addr,
  input  logic [15:0]       pm_rdata,
  output logic [DA_W-1:0]   dm_addr,
  output logic              dm_rd_en,
  input  logic [7:0]        dm_rdata,
  output logic              dm_wr_en,
  output logic [7:0]        dm_wdata,
  input  logic              pre_en,
  input  logic [7:0]        pre_w,
  input  logic              pre_carry,
  input  logic [BANK_W-1:0] pre_bsr,
  output logic [PC_W-1:0]   dbg_pc,
  output logic [7:0]        dbg_w,
  output logic              dbg_n,
  output logic              dbg_z,
  output logic              dbg_c
);

  phase_t            phase;
  logic              flush, exec;
  logic [IW-1:0]     ir;
  logic [BANK_W-1:0] bsr;
  logic              is_and, is_bc, dst_file, br_taken;
  logic [7:0]        br_off;

  assign exec = !flush;

  qpc_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (pre_en),
    .br_taken (br_taken),
    .phase    (phase),
    .flush    (flush)
  );

  qpc_decode #(.BANK_W(BANK_W), .ACC_SPLIT(ACC_SPLIT)) u_dec (
    .ir        (ir),
    .exec      (exec),
    .bsr       (bsr),
    .is_and    (is_and),
    .is_bc     (is_bc),
    .dst_file  (dst_file),
    .file_addr (dm_addr),
    .br_off    (br_off)
  );

  qpc_datapath #(.BANK_W(BANK_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .hold     (pre_en),
    .pre_w    (pre_w),
    .pre_c    (pre_carry),
    .pre_bsr  (pre_bsr),
    .pm_rdata (pm_rdata),
    .dm_rdata (dm_rdata),
    .is_and   (is_and),
    .is_bc    (is_bc),
    .dst_file (dst_file),
    .ir       (ir),
    .bsr      (bsr),
    .w        (dbg_w),
    .n_flag   (dbg_n),
    .z_flag   (dbg_z),
    .c_flag   (dbg_c),
    .rd_en    (dm_rd_en),
    .wr_en    (dm_wr_en),
    .wdata    (dm_wdata),
    .br_taken (br_taken)
  );

  qpc_pc #(.PC_W(PC_W)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .hold      (pre_en),
    .exec      (exec),
    .br_taken  (br_taken),
    .br_off    (br_off),
    .pc        (dbg_pc),
    .word_addr (pm_word_addr)
  );

  // R7: write-back always follows the operand read by two clocks
  a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    dm_wr_en |-> $past(dm_rd_en, 2));

endmodule

// File: tb/quad_phase_core_tb.sv
`timescale 1ns/1ps
module quad_phase_core_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] pm_word_addr;
  logic [15:0] pm_rdata;
  logic [11:0] dm_addr;
  logic        dm_rd_en, dm_wr_en;
  logic [7:0]  dm_rdata, dm_wdata;
  logic        pre_en;
  logic [7:0]  pre_w;
  logic        pre_carry;
  logic [3:0]  pre_bsr;
  logic [15:0] dbg_pc;
  logic [7:0]  dbg_w;
  logic        dbg_n, dbg_z, dbg_c;

  always #2.5 clk = ~clk;

  logic [15:0] pmem [0:63];
  logic [7:0]  dmem [0:4095];
  assign pm_rdata = pmem[pm_word_addr[5:0]];
  assign dm_rdata = dmem[dm_addr];
  always @(posedge clk) if (dm_wr_en) dmem[dm_addr] <= dm_wdata;

  quad_phase_core u_dut (
    .clk(clk), .rst_n(rst_n), .pm_word_addr(pm_word_addr), .pm_rdata(pm_rdata),
    .dm_addr(dm_addr), .dm_rd_en(dm_rd_en), .dm_rdata(dm_rdata), .dm_wr_en(dm_wr_en),
    .dm_wdata(dm_wdata), .pre_en(pre_en), .pre_w(pre_w), .pre_carry(pre_carry),
    .pre_bsr(pre_bsr), .dbg_pc(dbg_pc), .dbg_w(dbg_w), .dbg_n(dbg_n), .dbg_z(dbg_z),
    .dbg_c(dbg_c)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] ins;
    logic [7:0]  w;
    logic        c;
    logic [3:0]  bsr;
    logic [11:0] maddr;
    logic [7:0]  mval;
    logic [7:0]  ew;
    logic [7:0]  em;
    logic        en, ez, ec;
    logic [15:0] epc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  16'h1425, 8'h17, 1'b1, 4'h3, 12'h025, 8'hC2, 8'h02, 8'hC2, 1'b0, 1'b0, 1'b1, 16'h0002}, // R2
    '{4'd3,  16'h1610, 8'hF0, 1'b0, 4'h0, 12'h010, 8'h8F, 8'hF0, 8'h80, 1'b1, 1'b0, 1'b0, 16'h0002}, // R3
    '{4'd4,  16'h169A, 8'h3C, 1'b1, 4'h5, 12'hF9A, 8'hC3, 8'h3C, 8'h00, 1'b0, 1'b1, 1'b1, 16'h0002}, // R4 high half
    '{4'd5,  16'h1744, 8'hAA, 1'b0, 4'h7, 12'h744, 8'hFF, 8'hAA, 8'hAA, 1'b1, 1'b0, 1'b0, 16'h0002}, // R5 d=1
    '{4'd5,  16'h159A, 8'h0F, 1'b1, 4'h2, 12'h29A, 8'h3C, 8'h0C, 8'h3C, 1'b0, 1'b0, 1'b1, 16'h0002}, // R5 d=0
    '{4'd8,  16'hE205, 8'h55, 1'b1, 4'h0, 12'h000, 8'h00, 8'h55, 8'h00, 1'b0, 1'b0, 1'b1, 16'h000C}, // R8 +5
    '{4'd9,  16'hE205, 8'h55, 1'b0, 4'h0, 12'h000, 8'h00, 8'h55, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0002}, // R9
    '{4'd8,  16'hE2FD, 8'h66, 1'b1, 4'h0, 12'h000, 8'h00, 8'h66, 8'h00, 1'b0, 1'b0, 1'b1, 16'hFFFC}, // R8 -3 wraps
    '{4'd11, 16'h1825, 8'hFF, 1'b1, 4'h0, 12'h025, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 16'h0002}, // R11
    '{4'd11, 16'hE300, 8'h12, 1'b1, 4'h0, 12'h000, 8'h00, 8'h12, 8'h00, 1'b0, 1'b0, 1'b1, 16'h0002}, // R11
    '{4'd6,  16'h1401, 8'h00, 1'b1, 4'h0, 12'h001, 8'h5A, 8'h00, 8'h5A, 1'b0, 1'b1, 1'b1, 16'h0002}, // R6 zero
    '{4'd4,  16'h147F, 8'hFF, 1'b0, 4'h9, 12'h07F, 8'h81, 8'h81, 8'h81, 1'b1, 1'b0, 1'b0, 16'h0002}  // R4 low half
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reset, preload over one edge, release at a falling edge
  task automatic start(input logic [7:0] w, input logic c, input logic [3:0] b);
    rst_n = 1'b0;
    pre_en = 1'b0;
    repeat (2) @(negedge clk);
    pre_w = w; pre_carry = c; pre_bsr = b;
    pre_en = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) pmem[i] = 16'h0000;
    for (int i = 0; i < 4096; i++) dmem[i] = 8'h00;
    rst_n = 1'b0; pre_en = 1'b0; pre_w = 8'h00; pre_carry = 1'b0; pre_bsr = 4'h0;

    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "pc", dbg_pc, 16'h0000);
    chk("R1", "w", dbg_w, 8'h00);
    chk("R1", "nzc", {dbg_n, dbg_z, dbg_c}, 3'b000);
    chk("R1", "enables", {dm_rd_en, dm_wr_en}, 2'b00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string r;
      v = VECS[i];
      r = $sformatf("R%0d", v.req);
      pmem[0] = v.ins;
      dmem[v.maddr] = v.mval;
      start(v.w, v.c, v.bsr);
      clocks(4);
      chk(r, $sformatf("vec%0d pc", i), dbg_pc, v.epc);
      chk(r, $sformatf("vec%0d w", i), dbg_w, v.ew);
      chk(r, $sformatf("vec%0d mem", i), dmem[v.maddr], v.em);
      chk(r, $sformatf("vec%0d nzc", i), {dbg_n, dbg_z, dbg_c}, {v.en, v.ez, v.ec});
    end
    pmem[0] = 16'h0000;

    // R7: strobes in the right phases of an AND to memory
    pmem[0] = 16'h1610; dmem[12'h010] = 8'h3C;
    start(8'h0F, 1'b0, 4'h0);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      chk("R7", $sformatf("rd phase%0d", k), dm_rd_en, (k == 1));
      chk("R7", $sformatf("wr phase%0d", k), dm_wr_en, (k == 3));
    end
    clocks(0);
    @(posedge clk); @(negedge clk);
    chk("R7", "mem after four clocks", dmem[12'h010], 8'h0C);

    // R10: idle cycle after a taken branch
    pmem[0] = 16'hE205; pmem[6] = 16'h1610; dmem[12'h010] = 8'h8F;
    start(8'hF0, 1'b1, 4'h0);
    clocks(4);
    chk("R10", "target pc", dbg_pc, 16'h000C);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      chk("R10", $sformatf("quiet enables %0d", k), {dm_rd_en, dm_wr_en}, 2'b00);
      chk("R10", $sformatf("pc held %0d", k), dbg_pc, 16'h000C);
    end
    @(posedge clk); @(negedge clk);
    chk("R10", "pc after idle", dbg_pc, 16'h000C);
    chk("R10", "target not yet run", dmem[12'h010], 8'h8F);
    clocks(4);
    chk("R10", "target ran pc", dbg_pc, 16'h000E);
    chk("R10", "target ran mem", dmem[12'h010], 8'h80);
    pmem[0] = 16'h0000; pmem[6] = 16'h0000;

    // R9: fall-through followed immediately by next word
    pmem[0] = 16'hE205; pmem[1] = 16'h1425; dmem[12'h025] = 8'hC2;
    start(8'h17, 1'b0, 4'h0);
    clocks(8);
    chk("R9", "pc after two words", dbg_pc, 16'h0004);
    chk("R9", "second word result", dbg_w, 8'h02);
    pmem[0] = 16'h0000; pmem[1] = 16'h0000;

    // R12: preload stalls the core
    pmem[0] = 16'h1425; dmem[12'h025] = 8'hC2;
    rst_n = 1'b0; pre_en = 1'b0;
    repeat (2) @(negedge clk);
    pre_w = 8'h17; pre_carry = 1'b1; pre_bsr = 4'hA; pre_en = 1'b1; rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R12", $sformatf("pc held %0d", k), dbg_pc, 16'h0000);
      chk("R12", $sformatf("no access %0d", k), {dm_rd_en, dm_wr_en}, 2'b00);
    end
    chk("R12", "w loaded", dbg_w, 8'h17);
    chk("R12", "c loaded", dbg_c, 1'b1);
    pre_en = 1'b0;
    clocks(4);
    chk("R12", "runs after release", dbg_w, 8'h02);
    chk("R12", "pc after release", dbg_pc, 16'h0002);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule